// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Boundary Updates

This block drives four independent pulse-width modulated outputs from one clock. Each channel counts through a programmable period. It holds its output at the inactive level for a programmable number of counts and then drives it active for the rest of the period. A per-channel prescaler slows the count by a power of two. A per-channel polarity bit swaps which level counts as active.

Software controls the channels through a small register port that has separate write and read addresses. Two write-one registers start and stop channels. A status register shows which channels are running. A running channel can take a new duty or period value through its update register. The block holds that value and moves it into the working register only when the current period finishes, so no period is ever cut short or stretched by a change.

A per-channel flag register records every period start and is cleared by reading it. Software uses it to learn that a queued update is now active.

Top module: `pwm_quad_defer`

## Requirements
- R1: After reset all channels are stopped, every output is low, the status and flag registers read 0, and every channel register reads 0.
- R2: Writing address 0x00 starts every channel whose bit in the written value is 1, and leaves the other channels untouched. Address 0x08 reads back, in bits [3:0], a 1 for each running channel.
- R3: Writing address 0x04 stops every channel whose bit in the written value is 1. Bits written as 0 leave their channels running.
- R4: A started channel restarts its count from 0 at the start write. Each period lasts P counts, where P is the period register (a value of 0 acts as 1). The first D counts, where D is the duty register, are inactive and the remaining P-D counts are active. The output is registered: the count value of one cycle appears on the pin in the next cycle.
- R5: Bits [3:0] of the mode register (PRE, legal values 0..10; larger values act as 10) make the count advance once every 2^PRE clocks. The prescaler restarts at each start write.
- R6: Mode bit 4 inverts the output. A stopped channel drives the inactive level, which equals the value of mode bit 4.
- R7: A write to the update register of a running channel is held. At the end of the current period it is copied into the duty register when mode bit 5 is 0, or into the period register when mode bit 5 is 1. Until then the waveform is unchanged.
- R8: While a channel is stopped, an update-register write goes straight into the register that mode bit 5 selects, and direct writes to the duty and period registers always take effect at once.
- R9: Bit n of the flag register at address 0x0C is set when channel n is started and at every later period start of that channel.
- R10: A read of address 0x0C returns the flags and clears all of them. A period start in the same cycle as the clearing read stays set and shows in the next read.
- R11: The register bank of channel n sits at 0x20 + 0x10*n: the mode register at +0x0, duty at +0x4, period at +0x8 and update at +0xC. Read data appears in the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW (8) | Byte address of the read |
| rd_data | output | DW (32) | Read data, valid the cycle after rd_en |
| pwm_o | output | NCH (4) | Registered channel outputs |

## Verification
The assertions check on every cycle these properties of each channel:
- a stopped channel sits at its polarity level;
- a start write clears the count;
- a stop write halts the channel;
- the count is frozen between prescaler ticks;
- a period end with no competing write leaves no update pending;
- every period start lands in the flag register;
- a clearing read with no competing period start empties the flag register.

Only the bench scenarios can show the rest: the exact shape of the waveform for several periods, prescalers and polarities; that a queued duty or period change waits for the period boundary; the immediate path while a channel is stopped; and the ordering between a start and a clearing read in the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_MAX  = 10;
  localparam int PRE_W    = 4;
  localparam int MODE_W   = 6;
  localparam int PCNT_W   = PRE_MAX + 1;

  localparam int REG_START = 'h00;
  localparam int REG_STOP  = 'h04;
  localparam int REG_RUN   = 'h08;
  localparam int REG_FLAG  = 'h0C;
  localparam int CH_BASE   = 'h20;
  localparam int CH_SH     = 4;

  localparam logic [1:0] OFF_MODE = 2'd0;
  localparam logic [1:0] OFF_DUTY = 2'd1;
  localparam logic [1:0] OFF_PER  = 2'd2;
  localparam logic [1:0] OFF_UPD  = 2'd3;

  typedef struct packed {
    logic             upd_sel;
    logic             pol;
    logic [PRE_W-1:0] pre;
  } mode_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  logic [PCNT_W-1:0] pcnt_q;
  logic [PRE_W-1:0]  sel_c;
  logic [PCNT_W-1:0] mask;

  always_comb begin
    sel_c = (sel > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : sel;
    mask  = (PCNT_W'(1) << sel_c) - PCNT_W'(1);
    tick  = run && ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst)          pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + PCNT_W'(1);
  end

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(pcnt_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              mode_we,
  input  logic              duty_we,
  input  logic              per_we,
  input  logic              upd_we,
  input  logic [MODE_W-1:0] mode_wd,
  input  logic [PW-1:0]     wdata,
  output logic [MODE_W-1:0] mode_rb,
  output logic [PW-1:0]     duty_rb,
  output logic [PW-1:0]     per_rb,
  output logic [PW-1:0]     upd_rb,
  output logic              running,
  output logic              pstart,
  output logic              pwm_o
);
  mode_t         mode_q;
  logic [PW-1:0] duty_q, per_q, cnt_q, upd_q;
  logic          pend_q, run_q, out_q;
  logic          tick, last, wrap;
  logic [PW:0]   cnt_nx;

  pwm_prescale u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (run_q),
    .sel     (mode_q.pre),
    .tick    (tick)
  );

  always_comb begin
    cnt_nx = {1'b0, cnt_q} + (PW+1)'(1);
    last   = cnt_nx >= {1'b0, per_q};
    wrap   = run_q && tick && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (start)     run_q <= 1'b1;
      else if (stop) run_q <= 1'b0;
      if (start)          cnt_q <= '0;
      else if (wrap)      cnt_q <= '0;
      else if (run_q && tick) cnt_q <= cnt_nx[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
      upd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_t'(mode_wd);
      if (pend_q && (wrap || stop)) begin
        pend_q <= 1'b0;
        if (mode_q.upd_sel) per_q  <= upd_q;
        else                duty_q <= upd_q;
      end
      if (upd_we) begin
        upd_q <= wdata;
        if (run_q) pend_q <= 1'b1;
        else if (mode_q.upd_sel) per_q <= wdata;
        else duty_q <= wdata;
      end
      if (duty_we) duty_q <= wdata;
      if (per_we)  per_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= (run_q && (cnt_q >= duty_q)) ^ mode_q.pol;
  end

  assign mode_rb = mode_q;
  assign duty_rb = duty_q;
  assign per_rb  = per_q;
  assign upd_rb  = upd_q;
  assign running = run_q;
  assign pstart  = start || wrap;
  assign pwm_o   = out_q;

  // R2
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (running && cnt_q == '0));
  // R3
  stop_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !running);
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick && !start) |=> $stable(cnt_q));
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (pwm_o == $past(mode_q.pol)));
  // R7
  upd_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !upd_we) |=> !pend_q);
  // R8
  idle_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !pend_q && !start) |=> !pend_q);
endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [NCH-1:0]               wr_bits,
  input  logic                         rd_en,
  input  logic [AW-1:0]                rd_addr,
  output logic [DW-1:0]                rd_data,
  input  logic [NCH-1:0][MODE_W-1:0]   mode_rb,
  input  logic [NCH-1:0][PW-1:0]       duty_rb,
  input  logic [NCH-1:0][PW-1:0]       per_rb,
  input  logic [NCH-1:0][PW-1:0]       upd_rb,
  input  logic [NCH-1:0]               run_rb,
  input  logic [NCH-1:0]               pstart,
  output logic [NCH-1:0]               start_v,
  output logic [NCH-1:0]               stop_v,
  output logic [NCH-1:0]               mode_we,
  output logic [NCH-1:0]               duty_we,
  output logic [NCH-1:0]               per_we,
  output logic [NCH-1:0]               upd_we
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [AW-1:0]  wrel, widx, rrel, ridx;
  logic           wsel_ch, rsel_ch, flag_rd;
  logic [NCH-1:0] flag_q;
  logic [DW-1:0]  rmux, rd_q;
  logic [CHW-1:0] rch;
  logic           unused_lsb;

  always_comb begin
    wrel    = wr_addr - AW'(CH_BASE);
    widx    = wrel >> CH_SH;
    wsel_ch = wr_en && (wr_addr >= AW'(CH_BASE)) && (widx < AW'(NCH));
    start_v = (wr_en && wr_addr == AW'(REG_START)) ? wr_bits : '0;
    stop_v  = (wr_en && wr_addr == AW'(REG_STOP))  ? wr_bits : '0;
    for (int n = 0; n < NCH; n++) begin
      mode_we[n] = wsel_ch && (widx == AW'(n)) && (wrel[3:2] == OFF_MODE);
      duty_we[n] = wsel_ch && (widx == AW'(n)) && (wrel[3:2] == OFF_DUTY);
      per_we[n]  = wsel_ch && (widx == AW'(n)) && (wrel[3:2] == OFF_PER);
      upd_we[n]  = wsel_ch && (widx == AW'(n)) && (wrel[3:2] == OFF_UPD);
    end
  end

  always_comb begin
    rrel    = rd_addr - AW'(CH_BASE);
    ridx    = rrel >> CH_SH;
    rsel_ch = (rd_addr >= AW'(CH_BASE)) && (ridx < AW'(NCH));
    rch     = ridx[CHW-1:0];
    flag_rd = rd_en && (rd_addr == AW'(REG_FLAG));
    rmux    = '0;
    if (rd_addr == AW'(REG_RUN)) begin
      rmux[NCH-1:0] = run_rb;
    end else if (rd_addr == AW'(REG_FLAG)) begin
      rmux[NCH-1:0] = flag_q;
    end else if (rsel_ch) begin
      case (rrel[3:2])
        OFF_MODE: rmux[MODE_W-1:0] = mode_rb[rch];
        OFF_DUTY: rmux[PW-1:0]     = duty_rb[rch];
        OFF_PER:  rmux[PW-1:0]     = per_rb[rch];
        default:  rmux[PW-1:0]     = upd_rb[rch];
      endcase
    end
  end

  assign unused_lsb = ^{wrel[1:0], rrel[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      rd_q   <= '0;
    end else begin
      flag_q <= (flag_rd ? '0 : flag_q) | pstart;
      if (rd_en) rd_q <= rmux;
    end
  end

  assign rd_data = rd_q;

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pstart != '0) |=> ((flag_q & $past(pstart)) == $past(pstart)));
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && pstart == '0) |=> (flag_q == '0));
endmodule

// File: rtl/pwm_quad_defer.sv
module pwm_quad_defer
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_o
);
  logic [NCH-1:0][MODE_W-1:0] mode_rb;
  logic [NCH-1:0][PW-1:0]     duty_rb, per_rb, upd_rb;
  logic [NCH-1:0] run_rb, pstart, start_v, stop_v;
  logic [NCH-1:0] mode_we, duty_we, per_we, upd_we;
  logic           unused_wdata;

  assign unused_wdata = ^wr_data;

  pwm_regif #(.NCH(NCH), .PW(PW), .DW(DW), .AW(AW)) u_regif (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bits (wr_data[NCH-1:0]),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .mode_rb (mode_rb),
    .duty_rb (duty_rb),
    .per_rb  (per_rb),
    .upd_rb  (upd_rb),
    .run_rb  (run_rb),
    .pstart  (pstart),
    .start_v (start_v),
    .stop_v  (stop_v),
    .mode_we (mode_we),
    .duty_we (duty_we),
    .per_we  (per_we),
    .upd_we  (upd_we)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.PW(PW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .start   (start_v[g]),
      .stop    (stop_v[g]),
      .mode_we (mode_we[g]),
      .duty_we (duty_we[g]),
      .per_we  (per_we[g]),
      .upd_we  (upd_we[g]),
      .mode_wd (wr_data[MODE_W-1:0]),
      .wdata   (wr_data[PW-1:0]),
      .mode_rb (mode_rb[g]),
      .duty_rb (duty_rb[g]),
      .per_rb  (per_rb[g]),
      .upd_rb  (upd_rb[g]),
      .running (run_rb[g]),
      .pstart  (pstart[g]),
      .pwm_o   (pwm_o[g])
    );
  end
endmodule

// File: tb/pwm_quad_defer_bench.sv
module pwm_quad_defer_bench;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] pwm_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwm_quad_defer u_pwm_quad_defer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = int'(rd_data);
  endtask

  task automatic run_wave(input int ch, input int pre, input int p0, input int d0,
                          input int pol, input int sel, input bit do_upd, input int newv,
                          input int p1, input int d1, input string req);
    int base, n, m, c, d, bad, fa, fe;
    bit e;
    base = 'h20 + 16*ch; bad = 0; fa = 0; fe = 0;
    wr(base, pre | (pol << 4) | (sel << 5));
    wr(base + 8, p0);
    wr(base + 4, d0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h00; wr_data = DW'(1 << ch);
    @(negedge clk); wr_en = 1'b0;
    n = (p0 + 2*p1) << pre;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk); wr_en = 1'b0;
      m = (j - 1) >> pre;
      if (m < p0) begin c = m; d = d0; end
      else begin c = (m - p0) % p1; d = d1; end
      e = (c >= d) ^ pol[0];
      if (pwm_o[ch] !== e) begin
        if (bad == 0) begin fa = int'(pwm_o[ch]); fe = int'(e); end
        bad++;
      end
      if (do_upd && j == 3) begin
        wr_en = 1'b1; wr_addr = AW'(base + 12); wr_data = DW'(newv);
      end
    end
    check(bad == 0, req, fa, fe);
    wr('h04, 1 << ch);
  endtask

  task automatic t_reset();
    int v;
    rd('h08, v); check(v == 0, "R1 status", v, 0);
    rd('h0C, v); check(v == 0, "R1 flags", v, 0);
    rd('h28, v); check(v == 0, "R1 period ch0", v, 0);
    check(pwm_o == 0, "R1 outputs", int'(pwm_o), 0);
  endtask

  task automatic t_start_stop();
    int v;
    wr('h00, 'b0101); rd('h08, v); check(v == 'b0101, "R2 start W1", v, 'b0101);
    wr('h04, 'b0001); rd('h08, v); check(v == 'b0100, "R3 stop W1", v, 'b0100);
    wr('h04, 'b0000); rd('h08, v); check(v == 'b0100, "R3 zero bits ignored", v, 'b0100);
    wr('h20, 'h10); repeat (2) @(negedge clk);
    check(pwm_o[0] == 1'b1, "R6 idle level inverted", int'(pwm_o[0]), 1);
    wr('h20, 'h00); repeat (2) @(negedge clk);
    check(pwm_o[0] == 1'b0, "R6 idle level normal", int'(pwm_o[0]), 0);
    wr('h04, 'hF);
  endtask

  task automatic t_idle_writes();
    int v;
    wr('h30, 'h20); wr('h3C, 77);
    rd('h38, v); check(v == 77, "R8 idle update to period", v, 77);
    wr('h30, 'h00); wr('h3C, 33);
    rd('h34, v); check(v == 33, "R8 idle update to duty", v, 33);
    wr('h34, 12);
    rd('h34, v); check(v == 12, "R8 direct duty write", v, 12);
    rd('h30, v); check(v == 0, "R11 mode readback", v, 0);
    wr('h30, 'h20);
    rd('h30, v); check(v == 'h20, "R11 mode readback sel", v, 'h20);
  endtask

  task automatic t_flags();
    int v;
    rd('h0C, v);
    wr('h20, 0); wr('h28, 50); wr('h24, 10);
    wr('h00, 1);
    rd('h0C, v); check((v & 1) == 1, "R9 flag on start", v & 1, 1);
    rd('h0C, v); check((v & 1) == 0, "R10 read clears", v & 1, 0);
    repeat (60) @(negedge clk);
    rd('h0C, v); check((v & 1) == 1, "R9 flag on period start", v & 1, 1);
    wr('h04, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h2;
    rd_en = 1'b1; rd_addr = 8'h0C;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; v = int'(rd_data);
    check((v & 2) == 0, "R10 old value on same-cycle read", v & 2, 0);
    rd('h0C, v); check((v & 2) == 2, "R10 same-cycle start survives clear", v & 2, 2);
    wr('h04, 'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_wave(0, 0, 8, 3, 0, 0, 1'b0, 0, 8, 3, "R4 waveform P8 D3");
    run_wave(1, 2, 5, 1, 1, 0, 1'b0, 0, 5, 1, "R5 R6 prescale 4 inverted");
    run_wave(2, 0, 10, 2, 0, 0, 1'b1, 7, 10, 7, "R7 deferred duty");
    run_wave(3, 1, 6, 2, 0, 1, 1'b1, 9, 9, 2, "R7 deferred period");
    run_wave(0, 0, 4, 0, 0, 0, 1'b0, 0, 4, 0, "R4 zero duty all active");
    t_start_stop();
    t_idle_writes();
    t_flags();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule